// File: doc/BRIEF.md
# Carrier Deference Controller

This block is the deference state machine of a half-duplex Ethernet MAC. It watches a carrier-sense input, which is already synchronized to the clock, and tells the transmit process when the medium has been quiet for a full inter-frame gap. The transmit process may start a frame only while the gap-clear output is high.

A mode input picks how the 9.6 µs gap is timed after carrier falls.

- **Split mode (mode low):** the gap is timed as a 6.4 µs guarded segment and then a 3.2 µs committed segment. Carrier seen during the guarded segment sends the machine back to busy. Carrier seen during the committed segment is ignored, so the gap still completes.
- **Single mode (mode high):** one 9.6 µs timer runs after carrier falls, and carrier is ignored once it has started.

When the full-duplex flag is set, carrier sense plays no part and the gap is reported clear. Timer lengths come from a cycles-per-microsecond parameter.

Top module: `carrier_defer`

## Requirements
- R1: During synchronous reset the state becomes busy (code 0) if carrier is high and clear (code 4) if carrier is low. The gap-clear output follows: low for busy, high for clear.
- R2: In busy (code 0), the state holds while carrier is high. The first cycle carrier is sampled low starts gap timing: code 1 if mode is low, code 3 if mode is high. The mode is sampled only at that cycle.
- R3: In split mode the guarded segment (code 1) lasts exactly 32·C/5 cycles and the committed segment (code 2) lasts exactly 16·C/5 cycles, then the state becomes clear. C is the cycles-per-microsecond parameter.
- R4: Carrier sampled high in the guarded segment (code 1) moves the state to busy (code 0) on the next cycle, including on the segment's last cycle.
- R5: Carrier is ignored in the committed segment (code 2). The segment always runs to completion.
- R6: In single mode the single timer (code 3) lasts exactly 48·C/5 cycles whatever carrier does, then the state becomes clear.
- R7: In clear (code 4), a rising edge of carrier (high now, low on the previous cycle) moves the state to busy. Carrier that is already high on arrival in clear leaves the state in clear until it falls and rises again.
- R8: While the full-duplex flag is high, the next state is clear (code 4) whatever carrier does, and the gap-clear output is high.
- R9: The gap-clear output is a registered level that is high exactly in the cycles when the state code is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carrier_i | input | 1 | Synchronized carrier sense |
| single_mode_i | input | 1 | 1 = single 9.6 µs timer, 0 = split gap |
| full_duplex_i | input | 1 | Full-duplex flag, forces the gap clear |
| gap_clear_o | output | 1 | Deference finished; transmit may start |
| state_o | output | 3 | State code: 0 busy, 1 guarded, 2 committed, 3 single, 4 clear |

## Verification
The hardest cases to reach from the ports are carrier rising on the very last cycle of the guarded segment and carrier rising on the very first cycle of the committed segment. These two adjacent cycles must give opposite outcomes. The bench drives directed carrier pulses placed at exact cycle offsets from the carrier fall, so these two cycles are hit deliberately. It then runs long random carrier bursts, with random mode and occasional full-duplex, against a cycle model built from the requirements.

// File: rtl/cd_pkg.sv
package cd_pkg;
   typedef enum logic [2:0] {
      ST_BUSY  = 3'd0,
      ST_GUARD = 3'd1,
      ST_COMMIT = 3'd2,
      ST_SINGLE = 3'd3,
      ST_CLEAR = 3'd4
   } defer_st_e;
endpackage

// File: rtl/cd_edge.sv
module cd_edge (
   input  logic clk,
   input  logic rst,
   input  logic sig_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      prev_q <= sig_i;
   end

   assign rise_o = sig_i & ~prev_q & ~rst;
endmodule

// File: rtl/cd_timer.sv
module cd_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   // R3: the counter only ever moves down by one or is reloaded
   a_r3_count_down : assert property (@(posedge clk) disable iff (rst)
      (!$past(load_i) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cd_fsm.sv
module cd_fsm
   import cd_pkg::*;
#(
   parameter int CW = 8,
   parameter int GUARD_CYC = 32,
   parameter int COMMIT_CYC = 16,
   parameter int SINGLE_CYC = 48
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          carrier_i,
   input  logic          carrier_rise_i,
   input  logic          single_mode_i,
   input  logic          full_duplex_i,
   input  logic          tmr_zero_i,
   output logic          tmr_load_o,
   output logic [CW-1:0] tmr_val_o,
   output logic          gap_clear_o,
   output logic [2:0]    state_o
);
   localparam logic [CW-1:0] GUARD_LD  = CW'(GUARD_CYC - 1);
   localparam logic [CW-1:0] COMMIT_LD = CW'(COMMIT_CYC - 1);
   localparam logic [CW-1:0] SINGLE_LD = CW'(SINGLE_CYC - 1);

   defer_st_e st_q, st_d;
   logic      clear_q;

   always_comb begin
      st_d       = st_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      if (full_duplex_i) begin
         st_d = ST_CLEAR;
      end else begin
         unique case (st_q)
            ST_BUSY: begin
               if (!carrier_i) begin
                  tmr_load_o = 1'b1;
                  if (single_mode_i) begin
                     st_d      = ST_SINGLE;
                     tmr_val_o = SINGLE_LD;
                  end else begin
                     st_d      = ST_GUARD;
                     tmr_val_o = GUARD_LD;
                  end
               end
            end
            ST_GUARD: begin
               if (carrier_i) begin
                  st_d = ST_BUSY;
               end else if (tmr_zero_i) begin
                  st_d       = ST_COMMIT;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = COMMIT_LD;
               end
            end
            ST_COMMIT: begin
               if (tmr_zero_i) st_d = ST_CLEAR;
            end
            ST_SINGLE: begin
               if (tmr_zero_i) st_d = ST_CLEAR;
            end
            ST_CLEAR: begin
               if (carrier_rise_i) st_d = ST_BUSY;
            end
            default: st_d = ST_BUSY;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= carrier_i ? ST_BUSY : ST_CLEAR;
         clear_q <= ~carrier_i;
      end else begin
         st_q    <= st_d;
         clear_q <= (st_d == ST_CLEAR);
      end
   end

   assign gap_clear_o = clear_q;
   assign state_o     = st_q;

   // R2: carrier high keeps the machine busy
   a_r2_busy_hold : assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_BUSY && carrier_i && !full_duplex_i) |=> (st_q == ST_BUSY));
   // R4: carrier in the guarded segment restarts deference
   a_r4_guard_restart : assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_GUARD && carrier_i && !full_duplex_i) |=> (st_q == ST_BUSY));
   // R5: the committed segment is never left for busy
   a_r5_commit_no_busy : assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_COMMIT && !full_duplex_i) |=> (st_q == ST_COMMIT || st_q == ST_CLEAR));
   // R6: the single timer is never left for busy
   a_r6_single_no_busy : assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_SINGLE && !full_duplex_i) |=> (st_q == ST_SINGLE || st_q == ST_CLEAR));
   // R7: a rising carrier in clear returns to busy
   a_r7_clear_to_busy : assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_CLEAR && $rose(carrier_i) && !full_duplex_i) |=> (st_q == ST_BUSY));
   // R8: full duplex forces the gap clear
   a_r8_fdx_clear : assert property (@(posedge clk) disable iff (rst)
      full_duplex_i |=> gap_clear_o);
   // R9: the clear output agrees with the state code
   a_r9_clear_match : assert property (@(posedge clk) disable iff (rst)
      gap_clear_o == (st_q == ST_CLEAR));
endmodule

// File: rtl/carrier_defer.sv
module carrier_defer #(
   parameter int CYC_PER_US = 125
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       carrier_i,
   input  logic       single_mode_i,
   input  logic       full_duplex_i,
   output logic       gap_clear_o,
   output logic [2:0] state_o
);
   localparam int GUARD_CYC  = CYC_PER_US * 32 / 5;
   localparam int COMMIT_CYC = CYC_PER_US * 16 / 5;
   localparam int SINGLE_CYC = GUARD_CYC + COMMIT_CYC;
   localparam int CW         = $clog2(SINGLE_CYC + 1);

   generate
      if (CYC_PER_US < 5 || (CYC_PER_US % 5) != 0) begin : g_bad_rate
         $error("CYC_PER_US must be a positive multiple of 5");
      end
   endgenerate

   logic          rise;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_zero;

   cd_edge i_edge (
      .clk    (clk),
      .rst    (rst),
      .sig_i  (carrier_i),
      .rise_o (rise)
   );

   cd_timer #(.CW(CW)) i_timer (
      .clk        (clk),
      .rst        (rst),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   cd_fsm #(
      .CW         (CW),
      .GUARD_CYC  (GUARD_CYC),
      .COMMIT_CYC (COMMIT_CYC),
      .SINGLE_CYC (SINGLE_CYC)
   ) i_fsm (
      .clk            (clk),
      .rst            (rst),
      .carrier_i      (carrier_i),
      .carrier_rise_i (rise),
      .single_mode_i  (single_mode_i),
      .full_duplex_i  (full_duplex_i),
      .tmr_zero_i     (tmr_zero),
      .tmr_load_o     (tmr_load),
      .tmr_val_o      (tmr_val),
      .gap_clear_o    (gap_clear_o),
      .state_o        (state_o)
   );
endmodule

// File: tb/test_carrier_defer.sv
module test_carrier_defer;
   localparam int C  = 5;
   localparam int T1 = C * 32 / 5;
   localparam int T2 = C * 16 / 5;
   localparam int T3 = T1 + T2;

   logic clk = 0, rst = 1, crs = 0, smode = 0, fdx = 0;
   logic gap_clear;
   logic [2:0] state;
   int total = 0, bad = 0;
   bit model_on = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   carrier_defer #(.CYC_PER_US(C)) i_carrier_defer (
      .clk(clk), .rst(rst), .carrier_i(crs), .single_mode_i(smode),
      .full_duplex_i(fdx), .gap_clear_o(gap_clear), .state_o(state));

   // cycle model from the requirements
   int m_st, m_el;
   bit m_prev;
   always @(posedge clk) begin
      int s, e;
      s = m_st; e = m_el;
      if (rst) begin
         s = crs ? 0 : 4; e = 0;
      end else if (fdx) begin
         s = 4;
      end else begin
         case (m_st)
            0: if (!crs) begin s = smode ? 3 : 1; e = 0; end
            1: if (crs) s = 0;
               else if (m_el == T1 - 1) begin s = 2; e = 0; end
               else e = m_el + 1;
            2: if (m_el == T2 - 1) s = 4; else e = m_el + 1;
            3: if (m_el == T3 - 1) s = 4; else e = m_el + 1;
            default: if (crs && !m_prev) s = 0;
         endcase
      end
      m_st <= s; m_el <= e; m_prev <= crs;
   end

   function automatic string tag_of(int st, bit f);
      if (f) return "R8";
      case (st)
         0: return "R2";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   bit fdx_d;
   always @(negedge clk) begin
      if (model_on) begin
         check(tag_of(m_st, fdx_d), state, m_st);
         check("R9", gap_clear, m_st == 4);
      end
      fdx_d = fdx;
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // drive carrier low, wait n cycles, return state
   task automatic fall_and_wait(int n, output int st);
      crs = 0; cyc(n); st = state;
   endtask

   int st;
   initial begin
      // R1 reset with carrier high
      crs = 1; rst = 1; cyc(3);
      check("R1", state, 0); check("R1", gap_clear, 0);
      crs = 0; cyc(2);
      check("R1", state, 4); check("R1", gap_clear, 1);
      rst = 0; cyc(1);
      model_on = 1;
      check("R1", state, 4);

      // R7 rising edge returns to busy
      crs = 1; cyc(1); check("R7", state, 0);
      cyc(5); check("R2", state, 0);
      // R3 split gap timing
      smode = 0;
      fall_and_wait(1, st); check("R2", st, 1);
      cyc(T1 - 1); check("R3", state, 1);
      cyc(1); check("R3", state, 2);
      cyc(T2 - 1); check("R3", state, 2); check("R9", gap_clear, 0);
      cyc(1); check("R3", state, 4); check("R9", gap_clear, 1);

      // R4 carrier on last guarded cycle
      crs = 1; cyc(2); crs = 0; cyc(T1); crs = 1; cyc(1);
      check("R4", state, 0);
      // R5 carrier on first committed cycle is ignored
      crs = 0; cyc(T1 + 1); check("R5", state, 2);
      crs = 1; cyc(T2 - 1); check("R5", state, 2);
      cyc(1); check("R5", state, 4);
      // R7 carrier already high on arrival keeps clear
      cyc(4); check("R7", state, 4);
      crs = 0; cyc(1); crs = 1; cyc(1); check("R7", state, 0);

      // R6 single timer ignores carrier
      smode = 1; crs = 0; cyc(1); check("R6", state, 3);
      crs = 1; cyc(T3 - 1); check("R6", state, 3);
      cyc(1); check("R6", state, 4);

      // R8 full duplex
      fdx = 1; crs = 0; cyc(1); crs = 1; cyc(3);
      check("R8", state, 4); check("R8", gap_clear, 1);
      fdx = 0; crs = 0; cyc(2);

      // random bursts
      void'($urandom(32'h5eed));
      for (int i = 0; i < 2000; i++) begin
         int len;
         crs   = $urandom_range(0, 1);
         if ($urandom_range(0, 7) == 0) smode = $urandom_range(0, 1);
         fdx   = ($urandom_range(0, 31) == 0);
         len   = ($urandom_range(0, 3) == 0) ? $urandom_range(T1 - 2, T3 + 2)
                                             : $urandom_range(1, 12);
         cyc(len);
      end
      fdx = 0; cyc(2);
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done_flag) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule